// File: doc/BRIEF.md
# Source-Routed Wormhole Crossbar Switch

This block is a four-way on-chip network switch. Flits enter on four input links and leave on four output links. A packet is a head flit, any number of body flits, and a tail flit. A packet can also be a single flit that is both head and tail. The head flit carries the whole path through the network as a list of 2-bit hop selectors in the low bits of its payload. The switch reads the lowest selector to choose an output. It then shifts the path right by one selector before sending the flit on, so the next switch finds its own selector at the bottom.

Each input writes arriving flits into a four-entry buffer. Every output has its own round-robin arbiter. An output that grants a head flit stays reserved for that input until the tail flit has left. Flow control works by stall flags. The switch raises a stall toward each upstream sender when that input's buffer becomes nearly full. The switch sends nothing on an output while the downstream stall on that output is high. A flit that is written into an input buffer on one clock edge can appear on an output register on the next edge.

Top module: `wh_switch`

## Requirements
- R1: A synchronous active-low reset clears all outputs. After reset, out_valid and in_stall are all low and every output is free.
- R2: The switch writes a flit presented with in_valid into its input buffer at a clock edge. If the flit wins its output and out_stall is low in the following cycle, it appears with out_valid high after the next edge.
- R3: Flit bits [17:16] encode the kind: 01 is head, 00 is body, 10 is tail, 11 is single. A head or single flit goes to the output numbered by its payload bits [1:0]. On the way through, the switch shifts payload bits [7:0] right by 2 and fills the top with zeros. All other bits of the flit pass unchanged.
- R4: Once an output has forwarded a head flit from an input, it forwards flits only from that input until that input's tail flit has been sent. Packets from other inputs wait in their buffers.
- R5: Sending a tail flit frees its output. A single flit takes a free output and leaves it free after the same transfer.
- R6: When several inputs have a head or single flit for a free output, the first requesting input at or after the output's pointer wins. After reset the pointer is 0. The pointer moves to the input after the winner only when a new packet is granted.
- R7: When out_stall of an output is high in a cycle, that output loads no flit at the next edge, so out_valid is low in the following cycle. The flit stays buffered.
- R8: in_stall of an input is high exactly while its buffer holds 3 or more flits. A sender that obeys the stall never loses a flit.
- R9: Flits from one input leave the switch in the order they arrived.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| in_valid | input | 4 | One bit per input: a flit is present on that input |
| in_flit | input | 72 | Four 18-bit flits; input i uses bits [18*i+17:18*i] |
| in_stall | output | 4 | One bit per input: stall request to the upstream sender |
| out_valid | output | 4 | One bit per output: out_flit carries a flit |
| out_flit | output | 72 | Four 18-bit flits; output o uses bits [18*o+17:18*o] |
| out_stall | input | 4 | One bit per output: the downstream receiver cannot accept |

## Verification
Several cases are aimed at on purpose:
- **Same-cycle heads:** three single-flit packets reach one free output in the same cycle. A wrong pointer update would emit them out of order, or emit one of them twice.
- **Competing long packets:** two long packets target one output. If the grant were not held, their flits would interleave on that output.
- **Closing flits:** tail and single flits are mixed on one output. If an output were not freed, the next packet would never leave. If a single flit did reserve its output, it would block every packet behind it.
- **Stall and buffer fill:** stalls are held on every output while traffic fills the buffers, then random stall patterns follow. A design with the wrong stall threshold, or one that ignored out_stall, would drop flits, duplicate flits or send them early.

A behavioural model in the bench predicts every output and stall flag on every clock.

// File: rtl/wh_pkg.sv
// Shared flit kind encoding and helpers for the wormhole switch.
// Assumes the kind occupies the two most significant bits of every flit.
package wh_pkg;

    typedef enum logic [1:0] {
        KIND_BODY   = 2'b00,
        KIND_HEAD   = 2'b01,
        KIND_TAIL   = 2'b10,
        KIND_SINGLE = 2'b11
    } flit_kind_e;

    // True for a flit that starts a packet (head or single).
    function automatic logic opens_packet(flit_kind_e k);
        return k[0];
    endfunction

    // True for a flit that ends a packet (tail or single).
    function automatic logic closes_packet(flit_kind_e k);
        return k[1];
    endfunction

endpackage

// File: rtl/wh_in_fifo.sv
// Input buffer of one switch port: stores incoming flits in arrival order.
// Raises stall_up when it holds STALL_LVL or more flits, which leaves room
// for the flit that a registered upstream can still send. Assumes rd_en is
// only asserted while not_empty is high.
module wh_in_fifo #(
    parameter int FLIT_W    = 18,
    parameter int DEPTH     = 4,
    parameter int STALL_LVL = 3
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic [FLIT_W-1:0] wr_flit,
    input  logic              rd_en,
    output logic [FLIT_W-1:0] head_flit,
    output logic              not_empty,
    output logic              stall_up
);
    localparam int PTR_W = (DEPTH > 1) ? $clog2(DEPTH) : 1;
    localparam int CNT_W = $clog2(DEPTH + 1);

    logic [FLIT_W-1:0] mem [DEPTH];
    logic [PTR_W-1:0]  wptr, rptr;
    logic [CNT_W-1:0]  count;
    logic              wr_ok;

    assign wr_ok     = wr_en && ((count < CNT_W'(DEPTH)) || rd_en);
    assign head_flit = mem[rptr];
    assign not_empty = (count != '0);
    assign stall_up  = (count >= CNT_W'(STALL_LVL));

    // Storage write; contents need no reset.
    always_ff @(posedge clk) begin
        if (wr_ok) mem[wptr] <= wr_flit;
    end

    // Pointer and occupancy bookkeeping.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            wptr  <= '0;
            rptr  <= '0;
            count <= '0;
        end else begin
            if (wr_ok) wptr <= (wptr == PTR_W'(DEPTH - 1)) ? '0 : wptr + 1'b1;
            if (rd_en) rptr <= (rptr == PTR_W'(DEPTH - 1)) ? '0 : rptr + 1'b1;
            count <= count + CNT_W'(wr_ok) - CNT_W'(rd_en);
        end
    end

    assert_no_overflow_R8: assert property (@(posedge clk) disable iff (!rst_n)
        wr_en |-> ((count < CNT_W'(DEPTH)) || rd_en));

    assert_read_nonempty_R9: assert property (@(posedge clk) disable iff (!rst_n)
        rd_en |-> not_empty);

endmodule

// File: rtl/wh_out_port.sv
// One output of the switch: round-robin allocation among head flits, a
// wormhole lock held until the closing flit, the crossbar select, the route
// shift and the output register. Assumes req only marks inputs whose front
// flit opens a packet for this output.
module wh_out_port
    import wh_pkg::*;
#(
    parameter int NP      = 4,
    parameter int FLIT_W  = 18,
    parameter int ROUTE_W = 8,
    parameter int HOP_W   = 2
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic [NP-1:0]        req,
    input  logic [NP-1:0]        avail,
    input  logic [NP*FLIT_W-1:0] heads,
    input  logic                 stall_dn,
    output logic [NP-1:0]        serve,
    output logic                 out_valid,
    output logic [FLIT_W-1:0]    out_flit
);
    localparam int IDX_W = (NP > 1) ? $clog2(NP) : 1;

    logic              locked;
    logic [IDX_W-1:0]  owner, ptr, win, src;
    logic              found, send;
    logic [FLIT_W-1:0] sel_flit, fwd;
    flit_kind_e        kind;

    // Round-robin search starting at the pointer.
    always_comb begin
        found = 1'b0;
        win   = '0;
        for (int k = 0; k < NP; k++) begin
            int cand;
            cand = (int'(ptr) + k) % NP;
            if (!found && req[cand]) begin
                found = 1'b1;
                win   = IDX_W'(cand);
            end
        end
    end

    // Source choice, transfer decision and crossbar select.
    always_comb begin
        src      = locked ? owner : win;
        send     = !stall_dn && (locked ? avail[owner] : found);
        sel_flit = heads[src*FLIT_W +: FLIT_W];
        kind     = flit_kind_e'(sel_flit[FLIT_W-1 -: 2]);
        fwd      = sel_flit;
        if (opens_packet(kind))
            fwd[ROUTE_W-1:0] = sel_flit[ROUTE_W-1:0] >> HOP_W;
        serve = '0;
        if (send) serve[src] = 1'b1;
    end

    // Output register.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            out_valid <= 1'b0;
            out_flit  <= '0;
        end else begin
            out_valid <= send;
            if (send) out_flit <= fwd;
        end
    end

    // Wormhole lock and round-robin pointer.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            locked <= 1'b0;
            owner  <= '0;
            ptr    <= '0;
        end else if (send) begin
            if (!locked) begin
                ptr <= IDX_W'((int'(win) + 1) % NP);
                if (kind == KIND_HEAD) begin
                    locked <= 1'b1;
                    owner  <= win;
                end
            end else if (closes_packet(kind)) begin
                locked <= 1'b0;
            end
        end
    end

    assert_stall_blocks_R7: assert property (@(posedge clk) disable iff (!rst_n)
        stall_dn |=> !out_valid);

    assert_hold_owner_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (locked && !(send && closes_packet(kind))) |=> (locked && $stable(owner)));

    assert_release_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (send && closes_packet(kind)) |=> !locked);

    assert_grant_requester_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (send && !locked) |-> req[win]);

endmodule

// File: rtl/wh_switch.sv
// Four-way source-routed wormhole switch: per-input buffers feed per-output
// arbiters through a crossbar. Every flit is registered on entry and on
// exit. Assumes upstream senders obey in_stall and that the packets are
// well formed.
module wh_switch
    import wh_pkg::*;
#(
    parameter int NP         = 4,
    parameter int DATA_W     = 16,
    parameter int ROUTE_W    = 8,
    parameter int FIFO_DEPTH = 4,
    parameter int STALL_LVL  = 3
) (
    input  logic                              clk,
    input  logic                              rst_n,
    input  logic [NP-1:0]                     in_valid,
    input  logic [NP*(DATA_W+2)-1:0]          in_flit,
    output logic [NP-1:0]                     in_stall,
    output logic [NP-1:0]                     out_valid,
    output logic [NP*(DATA_W+2)-1:0]          out_flit,
    input  logic [NP-1:0]                     out_stall
);
    localparam int FLIT_W = DATA_W + 2;
    localparam int HOP_W  = (NP > 1) ? $clog2(NP) : 1;

    logic [FLIT_W-1:0]          head_q [NP];
    logic [NP*FLIT_W-1:0]       heads_flat;
    logic [NP-1:0]              not_empty, pop;
    logic [NP-1:0][NP-1:0]      req_m;    // [output][input]
    logic [NP-1:0][NP-1:0]      serve_m;  // [output][input]
    logic [NP-1:0][NP-1:0]      col_m;    // [input][output]

    // Input buffers.
    for (genvar i = 0; i < NP; i++) begin : g_in
        wh_in_fifo #(
            .FLIT_W   (FLIT_W),
            .DEPTH    (FIFO_DEPTH),
            .STALL_LVL(STALL_LVL)
        ) u_fifo (
            .clk      (clk),
            .rst_n    (rst_n),
            .wr_en    (in_valid[i]),
            .wr_flit  (in_flit[i*FLIT_W +: FLIT_W]),
            .rd_en    (pop[i]),
            .head_flit(head_q[i]),
            .not_empty(not_empty[i]),
            .stall_up (in_stall[i])
        );
        assign heads_flat[i*FLIT_W +: FLIT_W] = head_q[i];

        assert_one_dest_R4: assert property (@(posedge clk) disable iff (!rst_n)
            $countones(col_m[i]) <= 1);
    end

    // Route decode: a front flit that opens a packet requests its output.
    always_comb begin
        for (int o = 0; o < NP; o++) begin
            for (int i = 0; i < NP; i++) begin
                req_m[o][i] = not_empty[i]
                    && opens_packet(flit_kind_e'(head_q[i][FLIT_W-1 -: 2]))
                    && (head_q[i][HOP_W-1:0] == HOP_W'(o));
            end
        end
    end

    // Collect the pop of each input from all outputs.
    always_comb begin
        for (int i = 0; i < NP; i++) begin
            for (int o = 0; o < NP; o++) col_m[i][o] = serve_m[o][i];
            pop[i] = |col_m[i];
        end
    end

    // Output arbiters with crossbar and output registers.
    for (genvar o = 0; o < NP; o++) begin : g_out
        wh_out_port #(
            .NP     (NP),
            .FLIT_W (FLIT_W),
            .ROUTE_W(ROUTE_W),
            .HOP_W  (HOP_W)
        ) u_port (
            .clk      (clk),
            .rst_n    (rst_n),
            .req      (req_m[o]),
            .avail    (not_empty),
            .heads    (heads_flat),
            .stall_dn (out_stall[o]),
            .serve    (serve_m[o]),
            .out_valid(out_valid[o]),
            .out_flit (out_flit[o*FLIT_W +: FLIT_W])
        );
    end

endmodule

// File: tb/sim_wh_switch.sv
`timescale 1ns/1ps
module sim_wh_switch;
    localparam int NP = 4;
    localparam int FW = 18;

    logic              clk = 1'b0;
    logic              rst_n = 1'b0;
    logic [NP-1:0]     in_valid = '0;
    logic [NP*FW-1:0]  in_flit = '0;
    logic [NP-1:0]     out_stall = '0;
    logic [NP-1:0]     in_stall, out_valid;
    logic [NP*FW-1:0]  out_flit;

    wh_switch u0 (
        .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_flit(in_flit),
        .in_stall(in_stall), .out_valid(out_valid), .out_flit(out_flit),
        .out_stall(out_stall)
    );

    always #4 clk = ~clk;

    int n_checks = 0, n_err = 0, cyc = 0;
    string phase = "R1";
    bit hold = 1'b1, started = 1'b0;
    int stall_mode = 0;

    logic [FW-1:0] send_q [NP][$];
    logic [FW-1:0] mq [NP][$];
    bit            m_lock [NP];
    int            m_own [NP], m_ptr [NP];
    logic [NP-1:0] e_valid = '0;
    logic [FW-1:0] e_flit [NP];
    logic [7:0]    cap [$];

    task automatic chk(bit ok, string rq, string what, longint act, longint exp);
        n_checks++;
        if (!ok) begin
            n_err++;
            $display("FAIL %s %s phase=%s actual=%0h expected=%0h", rq, what, phase, act, exp);
        end
    endtask

    task automatic gen_pkt(int src, logic [7:0] route, int len, logic [7:0] tag);
        if (len <= 1) send_q[src].push_back({2'b11, tag, route});
        else begin
            send_q[src].push_back({2'b01, tag, route});
            for (int b = 0; b < len - 2; b++) send_q[src].push_back({2'b00, tag, 8'($urandom)});
            send_q[src].push_back({2'b10, tag, 8'($urandom)});
        end
    endtask

    // Reference model: updates on each edge from the inputs and its own state.
    always @(posedge clk) begin
        bit popm [NP];
        int s;
        logic [FW-1:0] f;
        started = 1'b1;
        if (!rst_n) begin
            for (int i = 0; i < NP; i++) begin
                mq[i].delete(); m_lock[i] = 0; m_own[i] = 0; m_ptr[i] = 0; e_flit[i] = '0;
            end
            e_valid = '0;
        end else begin
            for (int i = 0; i < NP; i++) popm[i] = 0;
            for (int o = 0; o < NP; o++) begin
                e_valid[o] = 1'b0;
                if (!out_stall[o]) begin
                    s = -1;
                    if (m_lock[o]) begin
                        if (mq[m_own[o]].size() > 0) s = m_own[o];
                    end else begin
                        for (int k = 0; k < NP; k++) begin
                            int i;
                            i = (m_ptr[o] + k) % NP;
                            if (s < 0 && mq[i].size() > 0 && mq[i][0][16] == 1'b1
                                && int'(mq[i][0][1:0]) == o) s = i;
                        end
                    end
                    if (s >= 0) begin
                        f = mq[s][0];
                        popm[s] = 1;
                        if (!m_lock[o]) begin
                            m_ptr[o] = (s + 1) % NP;
                            if (f[17:16] == 2'b01) begin m_lock[o] = 1; m_own[o] = s; end
                        end else if (f[17] == 1'b1) m_lock[o] = 0;
                        if (f[16]) f[7:0] = {2'b00, f[7:2]};
                        e_valid[o] = 1'b1;
                        e_flit[o]  = f;
                    end
                end
            end
            for (int i = 0; i < NP; i++) begin
                if (popm[i]) void'(mq[i].pop_front());
                if (in_valid[i]) mq[i].push_back(in_flit[i*FW +: FW]);
            end
        end
    end

    // Compare against the model, then drive the next inputs.
    always @(negedge clk) begin
        if (started) begin
            for (int o = 0; o < NP; o++) begin
                logic [FW-1:0] act;
                act = out_flit[o*FW +: FW];
                chk(out_valid[o] == e_valid[o], "R2", $sformatf("out%0d valid", o),
                    out_valid[o], e_valid[o]);
                if (e_valid[o])
                    chk(act == e_flit[o], "R3", $sformatf("out%0d flit", o), act, e_flit[o]);
                if (phase == "R6" && o == 0 && out_valid[0]) cap.push_back(act[15:8]);
            end
            for (int i = 0; i < NP; i++)
                chk(in_stall[i] == (mq[i].size() >= 3), "R8", $sformatf("in%0d stall", i),
                    in_stall[i], mq[i].size() >= 3);
        end
        for (int i = 0; i < NP; i++) begin
            if (!hold && send_q[i].size() > 0 && !in_stall[i]) begin
                in_valid[i] = 1'b1;
                in_flit[i*FW +: FW] = send_q[i].pop_front();
            end else in_valid[i] = 1'b0;
            out_stall[i] = (stall_mode == 2) ? 1'b1 :
                           (stall_mode == 1) ? (($urandom % 4) == 0) : 1'b0;
        end
    end

    function automatic bit idle();
        for (int i = 0; i < NP; i++)
            if (send_q[i].size() != 0 || mq[i].size() != 0 || m_lock[i]) return 0;
        return (e_valid == '0);
    endfunction

    task automatic drain();
        @(negedge clk);
        while (!idle()) @(negedge clk);
        repeat (4) @(negedge clk);
    endtask

    task automatic summary();
        $display("Result: errors=%0d of %0d checks", n_err, n_checks);
    endtask

    always @(posedge clk) begin
        cyc++;
        if (cyc >= 100000) begin
            n_checks++; n_err++;
            $display("FAIL watchdog actual=hung expected=done");
            summary();
            $finish;
        end
    end

    initial begin
        // R1: reset state.
        repeat (3) @(negedge clk);
        chk(out_valid == '0, "R1", "out_valid in reset", out_valid, 0);
        chk(in_stall == '0, "R1", "in_stall in reset", in_stall, 0);
        rst_n = 1'b1; hold = 1'b0;

        phase = "R2";
        @(posedge clk); gen_pkt(0, 8'h02, 1, 8'h11);
        drain();

        phase = "R3";
        @(posedge clk);
        gen_pkt(1, 8'hE7, 3, 8'h21);
        gen_pkt(2, 8'h01, 2, 8'h22);
        gen_pkt(3, 8'h5A, 4, 8'h23);
        drain();

        phase = "R4";
        @(posedge clk);
        gen_pkt(0, 8'h01, 5, 8'h31);
        gen_pkt(1, 8'h01, 4, 8'h32);
        gen_pkt(3, 8'h01, 1, 8'h33);
        drain();

        phase = "R5";
        @(posedge clk);
        gen_pkt(0, 8'h02, 1, 8'h41);
        gen_pkt(0, 8'h02, 3, 8'h42);
        gen_pkt(1, 8'h02, 1, 8'h43);
        gen_pkt(2, 8'h02, 2, 8'h44);
        gen_pkt(1, 8'h03, 1, 8'h45);
        drain();

        // R6: pin the pointer with a reset, then three same-cycle singles.
        rst_n = 1'b0; hold = 1'b1;
        repeat (2) @(negedge clk);
        rst_n = 1'b1; phase = "R6"; cap.delete();
        @(posedge clk);
        gen_pkt(1, 8'h00, 1, 8'hA1);
        gen_pkt(2, 8'h00, 1, 8'hA2);
        gen_pkt(3, 8'h00, 1, 8'hA3);
        hold = 1'b0;
        drain();
        chk(cap.size() == 3, "R6", "grant count", cap.size(), 3);
        if (cap.size() == 3) begin
            chk(cap[0] == 8'hA1, "R6", "first grant", cap[0], 8'hA1);
            chk(cap[1] == 8'hA2, "R6", "second grant", cap[1], 8'hA2);
            chk(cap[2] == 8'hA3, "R6", "third grant", cap[2], 8'hA3);
        end
        cap.delete(); hold = 1'b1;
        @(posedge clk);
        gen_pkt(3, 8'h00, 1, 8'hB3);
        gen_pkt(0, 8'h00, 1, 8'hB0);
        hold = 1'b0;
        drain();
        chk(cap.size() == 2, "R6", "round two count", cap.size(), 2);
        if (cap.size() == 2) begin
            chk(cap[0] == 8'hB0, "R6", "wrap grant first", cap[0], 8'hB0);
            chk(cap[1] == 8'hB3, "R6", "wrap grant second", cap[1], 8'hB3);
        end

        // R7 and R8: hold every output stalled while buffers fill.
        phase = "R7";
        stall_mode = 2;
        repeat (2) @(negedge clk);
        @(posedge clk);
        for (int i = 0; i < NP; i++) gen_pkt(i, 8'(i), 6, 8'h70 + 8'(i));
        repeat (10) @(negedge clk);
        chk(out_valid == '0, "R7", "no send while stalled", out_valid, 0);
        chk(in_stall == 4'hF, "R8", "buffers near full", in_stall, 4'hF);
        stall_mode = 0;
        drain();

        // R9: random traffic under random stalls; the model checks ordering.
        phase = "R9";
        stall_mode = 1;
        for (int p = 0; p < 300; p++) begin
            @(posedge clk);
            gen_pkt(int'($urandom % NP), 8'($urandom), 1 + int'($urandom % 4), 8'(p));
            if (p % 8 == 7) repeat (6) @(negedge clk);
        end
        stall_mode = 0;
        drain();

        summary();
        $finish;
    end
endmodule